// File: doc/BRIEF.md
# PnP Configuration Port Controller

This block is the configuration front end of a multi-function I/O chip. It decodes byte reads and writes to a pair of adjacent I/O addresses. The lower address is the index port and the upper address is the data port. Configuration space stays locked until the host writes a fixed key byte twice in a row to the index port. While the space is unlocked, the index port selects a register number and the data port reads or writes that register. Writing the exit key to the index port locks the space again.

Registers below 0x30 are global: the logical-device selector, a read-only identity and revision, per-function power-down bits and a whole-chip power-down bit. Registers at 0x30 and above form one bank per logical device. The logical-device selector chooses which bank is visible. Each bank holds an activate bit, three I/O base addresses, two interrupt numbers, a DMA channel and an option byte. The block exports each device's settings and a combined enable to the peripheral logic at all times, whether the space is locked or not.

Top module: `pnp_cfg_port`

## Requirements
- R1: The index port sits at `BASE_ADDR` and the data port at `BASE_ADDR+1`. Writes to any other address have no effect. A read of any other address returns 0xFF. While unlocked, a read of the index port returns the index currently selected.
- R2: The space unlocks only after two consecutive index-port writes of 0x87. An index-port write of any other value between them restarts the sequence. While unlocked, an index write of 0x87 simply selects index 0x87.
- R3: An index-port write of 0xAA while unlocked locks the space. That write does not change the selected index, and the index is kept across lock and unlock.
- R4: While locked, data-port writes are ignored, and reads of the data port and the index port return 0xFF.
- R5: Index 0x07 is the logical-device number (LDN). It is readable and writable, and it selects the bank seen at indices 0x30 and above.
- R6: Index 0x20 reads `DEV_ID` (default 0x97) and index 0x21 reads `DEV_REV` (default 0x01). Writes to either index have no effect.
- R7: Index 0x22 holds power-down bits, where a set bit means powered down. Bit 0 belongs to LDN 0 (floppy), bit 3 to LDN 1 (parallel), bit 4 to LDN 2 (serial A) and bit 5 to LDN 3 (serial B). All other bits read 0.
- R8: Bit 0 of index 0x23 is the whole-chip power-down. The other bits of that register read 0.
- R9: Each bank has the following registers, all of which read back what was written and are independent from bank to bank:
  - activate at 0x30, bit 0 only, other bits read 0;
  - base k high byte at 0x60+2k and low byte at 0x61+2k, for k = 0..2;
  - IRQ j at 0x70+2j, for j = 0..1;
  - DMA at 0x74;
  - option at 0xF0.
- R10: The following outputs continuously show the bank contents:
  - `dev_base_o[(d*NIO+k)*16 +: 16]` = {high, low};
  - `dev_irq_o[(d*NIRQ+j)*8 +: 8]`;
  - `dev_dma_o[d*8 +: 8]`;
  - `dev_opt_o[d*8 +: 8]`.
- R11: `dev_en_o[d]` is 1 only when these three hold: device d's activate bit is set, its R7 power-down bit (if it has one) is clear, and the chip power-down is clear.
- R12: `ecp_mode_o` equals bit 1 of the option register of LDN 1.
- R13: After reset the following hold:
  - the space is locked;
  - the index and the LDN are 0;
  - all bank registers, power-down bits and the chip power-down are 0.
- R14: While the LDN is `NDEV` or above, bank-index writes are ignored and bank-index reads return 0xFF. Unimplemented indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle per byte |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational, 0xFF when not addressed |
| dev_en_o | output | NDEV | Per-device effective enable |
| dev_base_o | output | NDEV*NIO*16 | Per-device I/O base addresses |
| dev_irq_o | output | NDEV*NIRQ*8 | Per-device IRQ numbers |
| dev_dma_o | output | NDEV*8 | Per-device DMA channel |
| dev_opt_o | output | NDEV*8 | Per-device option byte |
| ecp_mode_o | output | 1 | Parallel port extended mode |

## Verification
The exit key is the point where two functions meet in one cycle. The same index-port write both leaves the unlocked state and would, as an ordinary index write, load the index register. The bench points the index at the activate register, writes 0xAA, pokes the data port while locked, and then unlocks again. Reading back an index of 0x30 and an untouched activate bit, both seen through the ports, shows that only the lock took effect. The same collision is checked for 0x87 seen while partway through the key sequence and for 0x87 seen while already unlocked.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;

  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID     = 8'h20;
  localparam logic [7:0] IDX_REV    = 8'h21;
  localparam logic [7:0] IDX_PWR    = 8'h22;
  localparam logic [7:0] IDX_CHIP   = 8'h23;
  localparam logic [7:0] IDX_BANK   = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE0  = 8'h60;
  localparam logic [7:0] IDX_IRQ0   = 8'h70;
  localparam logic [7:0] IDX_DMA    = 8'h74;
  localparam logic [7:0] IDX_OPT    = 8'hF0;

  localparam logic [7:0] PWR_MASK   = 8'h39;
  localparam int         LDN_PAR    = 1;
  localparam int         OPT_ECP_BIT = 1;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;

  // slot in the function power-down vector, -1 when the device has none
  function automatic int pd_slot_of(int ldn);
    return (ldn >= 0 && ldn < 4) ? ldn : -1;
  endfunction
endpackage

// File: rtl/pnp_key_fsm.sv
module pnp_key_fsm
  import pnp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KEY_IDLE: state_d = (wdata_i == KEY_ENTER) ? KEY_HALF : KEY_IDLE;
        KEY_HALF: state_d = (wdata_i == KEY_ENTER) ? KEY_OPEN : KEY_IDLE;
        KEY_OPEN: state_d = (wdata_i == KEY_EXIT)  ? KEY_IDLE : KEY_OPEN;
        default:  state_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);
endmodule

// File: rtl/pnp_glob_regs.sv
module pnp_glob_regs
  import pnp_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID  = 8'h97,
  parameter logic [7:0] DEV_REV = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ldn_o,
  output logic [3:0] fn_pd_o,
  output logic       chip_pd_o,
  output logic [7:0] rdata_o
);
  logic [7:0] ldn_q;
  logic [7:0] pwr_q;
  logic       chip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q  <= '0;
      pwr_q  <= '0;
      chip_q <= 1'b0;
    end else if (wr_i) begin
      if (idx_i == IDX_LDN)  ldn_q  <= wdata_i;
      if (idx_i == IDX_PWR)  pwr_q  <= wdata_i & PWR_MASK;
      if (idx_i == IDX_CHIP) chip_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_LDN:  rdata_o = ldn_q;
      IDX_ID:   rdata_o = DEV_ID;
      IDX_REV:  rdata_o = DEV_REV;
      IDX_PWR:  rdata_o = pwr_q;
      IDX_CHIP: rdata_o = {7'b0, chip_q};
      default:  rdata_o = 8'h00;
    endcase
  end

  // slot order: floppy, parallel, serial A, serial B
  assign fn_pd_o   = {pwr_q[5], pwr_q[4], pwr_q[3], pwr_q[0]};
  assign ldn_o     = ldn_q;
  assign chip_pd_o = chip_q;
endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
  import pnp_cfg_pkg::*;
#(
  parameter int NIO  = 3,
  parameter int NIRQ = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [7:0]          idx_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  output logic                act_o,
  output logic [NIO*16-1:0]   base_o,
  output logic [NIRQ*8-1:0]   irq_o,
  output logic [7:0]          dma_o,
  output logic [7:0]          opt_o
);
  logic       act_q;
  logic [7:0] hi_q  [NIO];
  logic [7:0] lo_q  [NIO];
  logic [7:0] irq_q [NIRQ];
  logic [7:0] dma_q;
  logic [7:0] opt_q;
  logic       we;

  assign we = sel_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      dma_q <= '0;
      opt_q <= '0;
      for (int k = 0; k < NIO; k++) begin
        hi_q[k] <= '0;
        lo_q[k] <= '0;
      end
      for (int j = 0; j < NIRQ; j++) irq_q[j] <= '0;
    end else if (we) begin
      if (idx_i == IDX_ACT) act_q <= wdata_i[0];
      if (idx_i == IDX_DMA) dma_q <= wdata_i;
      if (idx_i == IDX_OPT) opt_q <= wdata_i;
      for (int k = 0; k < NIO; k++) begin
        if (idx_i == IDX_BASE0 + 8'(2*k))     hi_q[k] <= wdata_i;
        if (idx_i == IDX_BASE0 + 8'(2*k + 1)) lo_q[k] <= wdata_i;
      end
      for (int j = 0; j < NIRQ; j++)
        if (idx_i == IDX_IRQ0 + 8'(2*j)) irq_q[j] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (idx_i == IDX_ACT) rdata_o = {7'b0, act_q};
    if (idx_i == IDX_DMA) rdata_o = dma_q;
    if (idx_i == IDX_OPT) rdata_o = opt_q;
    for (int k = 0; k < NIO; k++) begin
      if (idx_i == IDX_BASE0 + 8'(2*k))     rdata_o = hi_q[k];
      if (idx_i == IDX_BASE0 + 8'(2*k + 1)) rdata_o = lo_q[k];
    end
    for (int j = 0; j < NIRQ; j++)
      if (idx_i == IDX_IRQ0 + 8'(2*j)) rdata_o = irq_q[j];
  end

  for (genvar k = 0; k < NIO; k++) begin : g_base
    assign base_o[k*16 +: 16] = {hi_q[k], lo_q[k]};
  end
  for (genvar j = 0; j < NIRQ; j++) begin : g_irq
    assign irq_o[j*8 +: 8] = irq_q[j];
  end

  assign act_o = act_q;
  assign dma_o = dma_q;
  assign opt_o = opt_q;
endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
  import pnp_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter int              NDEV      = 8,
  parameter int              NIO       = 3,
  parameter int              NIRQ      = 2,
  parameter logic [7:0]      DEV_ID    = 8'h97,
  parameter logic [7:0]      DEV_REV   = 8'h01
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        io_addr_i,
  input  logic                     io_wr_i,
  input  logic                     io_rd_i,
  input  logic [7:0]               io_wdata_i,
  output logic [7:0]               io_rdata_o,
  output logic [NDEV-1:0]          dev_en_o,
  output logic [NDEV*NIO*16-1:0]   dev_base_o,
  output logic [NDEV*NIRQ*8-1:0]   dev_irq_o,
  output logic [NDEV*8-1:0]        dev_dma_o,
  output logic [NDEV*8-1:0]        dev_opt_o,
  output logic                     ecp_mode_o
);
  localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic       idx_hit, dat_hit, idx_wr, data_wr;
  logic       cfg_open, chip_pd, ldn_ok, in_bank;
  logic [7:0] cfg_idx_q, ldn, glob_rd, cfg_rd;
  logic [3:0] fn_pd;
  logic [7:0] bank_rd [NDEV];
  logic [NDEV-1:0] act;

  assign idx_hit = (io_addr_i == BASE_ADDR);
  assign dat_hit = (io_addr_i == DATA_ADDR);
  assign idx_wr  = io_wr_i & idx_hit;
  assign data_wr = io_wr_i & dat_hit & cfg_open;
  assign in_bank = (cfg_idx_q >= IDX_BANK);
  assign ldn_ok  = (ldn < 8'(NDEV));

  pnp_key_fsm u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(idx_wr),
    .wdata_i (io_wdata_i),
    .open_o  (cfg_open)
  );

  // exit key locks without disturbing the selected index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cfg_idx_q <= '0;
    else if (idx_wr && cfg_open && io_wdata_i != KEY_EXIT) cfg_idx_q <= io_wdata_i;
  end

  pnp_glob_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glob (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (data_wr & ~in_bank),
    .idx_i    (cfg_idx_q),
    .wdata_i  (io_wdata_i),
    .ldn_o    (ldn),
    .fn_pd_o  (fn_pd),
    .chip_pd_o(chip_pd),
    .rdata_o  (glob_rd)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    localparam int PD_SLOT = pd_slot_of(d);

    pnp_dev_bank #(.NIO(NIO), .NIRQ(NIRQ)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (ldn == 8'(d)),
      .wr_i   (data_wr & in_bank),
      .idx_i  (cfg_idx_q),
      .wdata_i(io_wdata_i),
      .rdata_o(bank_rd[d]),
      .act_o  (act[d]),
      .base_o (dev_base_o[d*NIO*16 +: NIO*16]),
      .irq_o  (dev_irq_o[d*NIRQ*8 +: NIRQ*8]),
      .dma_o  (dev_dma_o[d*8 +: 8]),
      .opt_o  (dev_opt_o[d*8 +: 8])
    );

    if (PD_SLOT >= 0) begin : g_pd
      assign dev_en_o[d] = act[d] & ~fn_pd[PD_SLOT] & ~chip_pd;
    end else begin : g_nopd
      assign dev_en_o[d] = act[d] & ~chip_pd;
    end
  end

  always_comb begin
    if (!in_bank)    cfg_rd = glob_rd;
    else if (ldn_ok) cfg_rd = bank_rd[ldn[LDN_W-1:0]];
    else             cfg_rd = 8'hFF;
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i && cfg_open) begin
      if (idx_hit)      io_rdata_o = cfg_idx_q;
      else if (dat_hit) io_rdata_o = cfg_rd;
    end
  end

  assign ecp_mode_o = dev_opt_o[LDN_PAR*8 + OPT_ECP_BIT];
endmodule

// File: rtl/pnp_cfg_port_chk.sv
module pnp_cfg_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter int                NDEV      = 8,
  parameter logic [7:0]        DEV_ID    = 8'h97
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic [NDEV-1:0]   dev_en_o,
  input logic              cfg_open,
  input logic              chip_pd,
  input logic [7:0]        cfg_idx
);
  logic idx_a, dat_a;
  assign idx_a = (io_addr_i == BASE_ADDR);
  assign dat_a = (io_addr_i == BASE_ADDR + ADDR_W'(1));

  p_outside_ff_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !idx_a && !dat_a) |-> io_rdata_o == 8'hFF);

  p_unlock_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open) |-> $past(io_wr_i && idx_a && io_wdata_i == 8'h87));

  p_exit_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && io_wr_i && idx_a && io_wdata_i == 8'hAA) |=> !cfg_open);

  p_exit_keeps_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && idx_a && io_wdata_i == 8'hAA) |=> $stable(cfg_idx));

  p_locked_ff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open && io_rd_i && (idx_a || dat_a)) |-> io_rdata_o == 8'hFF);

  p_id_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && io_rd_i && dat_a && cfg_idx == 8'h20) |-> io_rdata_o == DEV_ID);

  p_chip_pd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_pd |-> dev_en_o == '0);
endmodule

bind pnp_cfg_port pnp_cfg_port_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NDEV(NDEV), .DEV_ID(DEV_ID)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_addr_i (io_addr_i),
  .io_wr_i   (io_wr_i),
  .io_rd_i   (io_rd_i),
  .io_wdata_i(io_wdata_i),
  .io_rdata_o(io_rdata_o),
  .dev_en_o  (dev_en_o),
  .cfg_open  (cfg_open),
  .chip_pd   (chip_pd),
  .cfg_idx   (cfg_idx_q)
);

// File: tb/pnp_cfg_port_tb.sv
module pnp_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 8, NIO = 3, NIRQ = 2;
  localparam logic [15:0] IA = 16'h002E;
  localparam logic [15:0] DA = 16'h002F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [NDEV-1:0] dev_en;
  logic [NDEV*NIO*16-1:0] dev_base;
  logic [NDEV*NIRQ*8-1:0] dev_irq;
  logic [NDEV*8-1:0] dev_dma, dev_opt;
  logic ecp;

  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnp_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .dev_en_o(dev_en), .dev_base_o(dev_base), .dev_irq_o(dev_irq),
    .dev_dma_o(dev_dma), .dev_opt_o(dev_opt), .ecp_mode_o(ecp)
  );

  // entry: {req[3:0], op[1:0], val[7:0]}; op 0 idx wr, 1 data wr, 2 data rd, 3 idx rd
  function automatic logic [13:0] v(int r, int op, int val);
    return {4'(r), 2'(op), 8'(val)};
  endfunction

  localparam int NV = 48;
  localparam logic [13:0] VEC [NV] = '{
    v(2,0,8'h87), v(2,0,8'h87),                       // R2 unlock
    v(6,0,8'h20), v(6,2,8'h97), v(6,0,8'h21), v(6,2,8'h01),
    v(6,1,8'h55), v(6,2,8'h01),                       // R6 read-only
    v(5,0,8'h07), v(5,1,8'h01), v(5,2,8'h01),         // R5 LDN 1
    v(9,0,8'h60), v(9,1,8'h03), v(9,0,8'h61), v(9,1,8'h78),
    v(9,0,8'h60), v(9,2,8'h03), v(9,0,8'h61), v(9,2,8'h78), // R9 base
    v(12,0,8'hF0), v(12,1,8'h02),                     // R12 option
    v(9,0,8'h30), v(9,1,8'hFF), v(9,2,8'h01),         // R9 activate bit 0
    v(5,0,8'h07), v(5,1,8'h00), v(9,0,8'h30), v(9,2,8'h00), // R9 banks apart
    v(7,0,8'h22), v(7,1,8'hFF), v(7,2,8'h39),         // R7 mask
    v(8,0,8'h23), v(8,1,8'hFF), v(8,2,8'h01), v(8,1,8'h00), // R8
    v(14,0,8'h07), v(14,1,8'h09), v(14,0,8'h30), v(14,1,8'h01),
    v(14,2,8'hFF), v(14,0,8'h07), v(14,1,8'h00),      // R14 LDN out of range
    v(14,0,8'h40), v(14,2,8'h00),                     // R14 unimplemented
    v(1,3,8'h40),                                     // R1 index readback
    v(3,0,8'hAA), v(4,2,8'hFF), v(4,3,8'hFF)          // R3 exit, R4 locked
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(IA, 8'h87); wr(IA, 8'h87);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk("R13 en", 32'(dev_en), 0);
    chk("R13 base", 32'(|dev_base), 0);
    chk("R13 ecp", 32'(ecp), 0);
    rd(DA, rv); chk("R13 locked", 32'(rv), 32'hFF);
    unlock();
    rd(IA, rv); chk("R13 idx", 32'(rv), 0);
    wr(IA, 8'h07); rd(DA, rv); chk("R13 ldn", 32'(rv), 0);
    wr(IA, 8'hAA);

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0] r  = VEC[i][13:10];
      automatic logic [1:0] op = VEC[i][9:8];
      automatic logic [7:0] vl = VEC[i][7:0];
      case (op)
        2'd0: wr(IA, vl);
        2'd1: wr(DA, vl);
        2'd2: begin rd(DA, rv); chk($sformatf("R%0d vec%0d", r, i), 32'(rv), 32'(vl)); end
        default: begin rd(IA, rv); chk($sformatf("R%0d vec%0d", r, i), 32'(rv), 32'(vl)); end
      endcase
    end

    chk("R12 ecp", 32'(ecp), 1);
    chk("R10 ldn1 base0", 32'(dev_base[(1*NIO+0)*16 +: 16]), 32'h0378);
    chk("R11 pd bit3", 32'(dev_en[1]), 0);

    // R3/R4: exit keeps index, locked data write ignored
    unlock(); wr(IA, 8'h22); wr(DA, 8'h00);
    wr(IA, 8'h07); wr(DA, 8'h00); wr(IA, 8'h30);
    wr(IA, 8'hAA); wr(DA, 8'h01);
    chk("R4 locked write", 32'(dev_en[0]), 0);
    chk("R11 ldn1 on", 32'(dev_en[1]), 1);
    unlock();
    rd(IA, rv); chk("R3 idx kept", 32'(rv), 32'h30);
    rd(DA, rv); chk("R4 act untouched", 32'(rv), 0);

    // R11 enable composition
    wr(DA, 8'h01); chk("R11 act", 32'(dev_en[0]), 1);
    wr(IA, 8'h22); wr(DA, 8'h01); chk("R11 fn pd", 32'(dev_en[0]), 0);
    wr(DA, 8'h00); chk("R11 fn pd clr", 32'(dev_en[0]), 1);
    wr(IA, 8'h23); wr(DA, 8'h01); chk("R11 chip pd", 32'(dev_en), 0);
    wr(DA, 8'h00);
    wr(IA, 8'h07); wr(DA, 8'h04); wr(IA, 8'h30); wr(DA, 8'h01);
    wr(IA, 8'h22); wr(DA, 8'h39); chk("R11 no pd bit", 32'(dev_en), 32'h10);
    wr(DA, 8'h00); chk("R11 all", 32'(dev_en), 32'h13);

    // R10 exported settings, also while locked
    wr(IA, 8'h07); wr(DA, 8'h02);
    wr(IA, 8'h64); wr(DA, 8'h12); wr(IA, 8'h65); wr(DA, 8'h34);
    wr(IA, 8'h72); wr(DA, 8'h0B); wr(IA, 8'h74); wr(DA, 8'h03);
    wr(IA, 8'hAA);
    chk("R10 base", 32'(dev_base[(2*NIO+2)*16 +: 16]), 32'h1234);
    chk("R10 irq", 32'(dev_irq[(2*NIRQ+1)*8 +: 8]), 32'h0B);
    chk("R10 dma", 32'(dev_dma[2*8 +: 8]), 32'h03);

    // R2 broken key sequence
    wr(IA, 8'h87); wr(IA, 8'h55); wr(IA, 8'h87);
    rd(DA, rv); chk("R2 broken seq", 32'(rv), 32'hFF);
    wr(IA, 8'h87);
    rd(IA, rv); chk("R2 open", 32'(rv), 32'h74);
    wr(IA, 8'h87); rd(DA, rv); chk("R2 key as index", 32'(rv), 0);
    wr(IA, 8'h74);

    // R1 address decode
    wr(16'h0030, 8'h99);
    rd(DA, rv); chk("R1 outside write", 32'(rv), 32'h03);
    rd(16'h002C, rv); chk("R1 outside read", 32'(rv), 32'hFF);

    // R13 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R13 en", 32'(dev_en), 0);
    chk("R13 dma", 32'(|dev_dma), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(DA, rv); chk("R13 relock", 32'(rv), 32'hFF);
    unlock();
    rd(IA, rv); chk("R13 idx clr", 32'(rv), 0);

    report();
  end
endmodule